// File: doc/BRIEF.md
# Window-Gated Thermometer-Code Digital PWM Controller

This block is the digital duty-cycle controller of a low-power step-down converter. A slow reference period is derived from a fast clock. At the start of each reference period the block raises its PWM output. The rising edge then runs down a tapped delay chain of 32 stages, and each stage lasts a fixed number of fast-clock cycles. The pulse ends at the first stage whose bit in the duty code is clear. The duty code is a low-filled thermometer code. It moves one position per update, in the direction given by a comparator that checks the output voltage against its reference.

Two more comparators mark the edges of a dead-band window around the reference. While either of them fires, the code is updated on every reference tick. While the output sits inside the window, the code is updated only once every sixteen reference ticks. A free-running divider sets that slower rate, and it cuts the controller's switching activity. All three comparator inputs are resynchronised on reference ticks before use. The update rate is selected with an explicit clock enable, so no shortened update slot can occur.

Top module: `dpwm_top`

## Requirements
- R1: While reset is asserted, and right after it, the duty code holds its 16 low bits set (bits 15..0 = 1, bits 31..16 = 0), the PWM output is low, the divided-rate flag is 1, and the divide-by-16 counter is zero. The first reference tick comes REF_CYC+2 clock edges after reset is released (2 edges for the reset synchroniser, then one tick every REF_CYC edges).
- R2: The PWM output rises in the clock cycle that follows each reference tick, and only then.
- R3: Each pulse lasts exactly (k+1)*STAGE_CYC clock cycles, where k is the number of ones in the duty code after the update made at that tick.
- R4: On an enabled update where the synchronised below-reference input is 1, one more bit of the code is set. The code always keeps the form bits [k-1:0] = 1 and the rest 0.
- R5: On an enabled update where the synchronised below-reference input is 0, the highest set bit of the code is cleared.
- R6: An upward update of a code with all 32 bits set leaves it unchanged.
- R7: A downward update of a code with only bit 0 set leaves it unchanged. Bit 0 is never clear.
- R8: While the synchronised above-high or below-low input is 1, the code is updated on every reference tick.
- R9: While both synchronised window inputs are 0, the code is updated only on the ticks where the free-running modulo-16 tick counter is at 15. That counter advances on every tick, whichever rate is selected.
- R10: Each comparator input is sampled on a reference tick and acts at the second tick after that one. This gives two tick-rate flops.
- R11: The divided-rate flag is 1 exactly when both synchronised window inputs are 0. It changes only in the cycle after a reference tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock; delay stages and the reference period are counted in it |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| vout_above_hi_i | input | 1 | Comparator: output above the upper window threshold |
| vout_below_lo_i | input | 1 | Comparator: output below the lower window threshold |
| vout_below_ref_i | input | 1 | Comparator: output below the centre reference (1 = lengthen pulse) |
| pwm_o | output | 1 | PWM drive signal |
| duty_code_o | output | NSTG | Thermometer duty code, bit 0 = first tap |
| div_sel_o | output | 1 | 1 while the divided update rate is selected |

## Verification
The bench builds the block with STAGE_CYC=2 and REF_CYC=80. A full 33-stage pulse (66 cycles) then fits inside one 80-cycle reference period, so every pulse width can be measured in full within its own period. These short periods let a run of about 150 reference ticks cover several things: both saturation ends, several 16-tick windows at the divided rate, and a mid-run reset that shows the divider restarting from zero. The bench keeps its own tick-level model of the synchroniser, the modulo-16 counter and the code's ones count.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;
  localparam int DEF_NSTG      = 32;
  localparam int DEF_STAGE_CYC = 4;
  localparam int DEF_REF_CYC   = 160;
  localparam int DEF_DIV_RATIO = 16;

  typedef enum logic {
    SHIFT_DN = 1'b0,
    SHIFT_UP = 1'b1
  } shift_dir_e;

  typedef struct packed {
    logic above_hi;
    logic below_lo;
    logic below_ref;
  } cmp_vec_t;
endpackage

// File: rtl/dpwm_timebase.sv
module dpwm_timebase #(
  parameter int REF_CYC   = dpwm_pkg::DEF_REF_CYC,
  parameter int DIV_RATIO = dpwm_pkg::DEF_DIV_RATIO
) (
  input  logic clk,
  input  logic rst_n,
  output logic ref_tick_o,
  output logic div_wrap_o
);
  localparam int RCW = (REF_CYC > 1) ? $clog2(REF_CYC) : 1;
  localparam int DCW = (DIV_RATIO > 1) ? $clog2(DIV_RATIO) : 1;
  localparam logic [RCW-1:0] RC_LAST = RCW'(REF_CYC - 1);
  localparam logic [DCW-1:0] DC_LAST = DCW'(DIV_RATIO - 1);

  logic [RCW-1:0] rc_q, rc_d;
  logic [DCW-1:0] dc_q, dc_d;
  logic           tick;

  always_comb begin
    tick = (rc_q == RC_LAST);
    rc_d = tick ? '0 : rc_q + 1'b1;
    dc_d = dc_q;
    if (tick) begin
      dc_d = (dc_q == DC_LAST) ? '0 : dc_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rc_q <= '0;
      dc_q <= '0;
    end else begin
      rc_q <= rc_d;
      dc_q <= dc_d;
    end
  end

  assign ref_tick_o = tick;
  assign div_wrap_o = tick && (dc_q == DC_LAST);
endmodule

// File: rtl/dpwm_gate_ctrl.sv
module dpwm_gate_ctrl
  import dpwm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_tick_i,
  input  logic       div_wrap_i,
  input  cmp_vec_t   cmp_i,
  output logic       shift_en_o,
  output shift_dir_e shift_dir_o,
  output logic       div_sel_o
);
  cmp_vec_t s1_q, s1_d, s2_q, s2_d;
  logic     in_window;

  always_comb begin
    s1_d = s1_q;
    s2_d = s2_q;
    if (ref_tick_i) begin
      s1_d = cmp_i;
      s2_d = s1_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= s1_d;
      s2_q <= s2_d;
    end
  end

  always_comb begin
    in_window   = !s2_q.above_hi && !s2_q.below_lo;
    shift_en_o  = ref_tick_i && (!in_window || div_wrap_i);
    shift_dir_o = s2_q.below_ref ? SHIFT_UP : SHIFT_DN;
    div_sel_o   = in_window;
  end
endmodule

// File: rtl/dpwm_therm_sr.sv
module dpwm_therm_sr
  import dpwm_pkg::*;
#(
  parameter int NSTG     = DEF_NSTG,
  parameter int RST_ONES = DEF_NSTG / 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            shift_en_i,
  input  shift_dir_e      shift_dir_i,
  output logic [NSTG-1:0] code_o
);
  function automatic logic [NSTG-1:0] therm(input int k);
    logic [NSTG-1:0] v;
    v = '0;
    for (int i = 0; i < NSTG; i++) begin
      if (i < k) v[i] = 1'b1;
    end
    return v;
  endfunction

  localparam logic [NSTG-1:0] RST_CODE = therm(RST_ONES);

  logic [NSTG-1:0] code_q, code_d;
  logic            at_top, at_floor;

  always_comb begin
    at_top   = code_q[NSTG-1];
    at_floor = !code_q[1];
    code_d   = code_q;
    if (shift_en_i) begin
      if (shift_dir_i == SHIFT_UP) begin
        if (!at_top) code_d = {code_q[NSTG-2:0], 1'b1};
      end else begin
        if (!at_floor) code_d = {1'b0, code_q[NSTG-1:1]};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) code_q <= RST_CODE;
    else        code_q <= code_d;
  end

  assign code_o = code_q;
endmodule

// File: rtl/dpwm_delay_chain.sv
module dpwm_delay_chain #(
  parameter int NSTG      = dpwm_pkg::DEF_NSTG,
  parameter int STAGE_CYC = dpwm_pkg::DEF_STAGE_CYC
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [NSTG-1:0] code_i,
  output logic            pwm_o
);
  localparam int SW   = $clog2(NSTG);
  localparam int SUBW = (STAGE_CYC > 1) ? $clog2(STAGE_CYC) : 1;
  localparam logic [SW:0]     ST_END   = (SW+1)'(NSTG);
  localparam logic [SUBW-1:0] SUB_LAST = SUBW'(STAGE_CYC - 1);

  logic            pwm_q, pwm_d;
  logic [SW:0]     st_q, st_d;
  logic [SUBW-1:0] sub_q, sub_d;
  logic            last_stage;

  always_comb begin
    if (st_q == ST_END) last_stage = 1'b1;
    else                last_stage = !code_i[st_q[SW-1:0]];
    pwm_d = pwm_q;
    st_d  = st_q;
    sub_d = sub_q;
    if (start_i) begin
      pwm_d = 1'b1;
      st_d  = '0;
      sub_d = '0;
    end else if (pwm_q) begin
      if (sub_q == SUB_LAST) begin
        sub_d = '0;
        if (last_stage) pwm_d = 1'b0;
        else            st_d  = st_q + 1'b1;
      end else begin
        sub_d = sub_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwm_q <= 1'b0;
      st_q  <= '0;
      sub_q <= '0;
    end else begin
      pwm_q <= pwm_d;
      st_q  <= st_d;
      sub_q <= sub_d;
    end
  end

  assign pwm_o = pwm_q;
endmodule

// File: rtl/dpwm_top.sv
module dpwm_top
  import dpwm_pkg::*;
#(
  parameter int NSTG      = DEF_NSTG,
  parameter int STAGE_CYC = DEF_STAGE_CYC,
  parameter int REF_CYC   = DEF_REF_CYC,
  parameter int DIV_RATIO = DEF_DIV_RATIO
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            vout_above_hi_i,
  input  logic            vout_below_lo_i,
  input  logic            vout_below_ref_i,
  output logic            pwm_o,
  output logic [NSTG-1:0] duty_code_o,
  output logic            div_sel_o
);
  localparam int RST_ONES = NSTG / 2;

  logic       rsync1_q, rsync2_q;
  logic       rst_sync_n;
  logic       ref_tick, div_wrap, shift_en;
  shift_dir_e shift_dir;
  cmp_vec_t   cmp_raw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsync1_q <= 1'b0;
      rsync2_q <= 1'b0;
    end else begin
      rsync1_q <= 1'b1;
      rsync2_q <= rsync1_q;
    end
  end
  assign rst_sync_n = rsync2_q;

  always_comb begin
    cmp_raw.above_hi  = vout_above_hi_i;
    cmp_raw.below_lo  = vout_below_lo_i;
    cmp_raw.below_ref = vout_below_ref_i;
  end

  dpwm_timebase #(.REF_CYC(REF_CYC), .DIV_RATIO(DIV_RATIO)) tb_u (
    .clk(clk), .rst_n(rst_sync_n), .ref_tick_o(ref_tick), .div_wrap_o(div_wrap)
  );

  dpwm_gate_ctrl gate_u (
    .clk(clk), .rst_n(rst_sync_n), .ref_tick_i(ref_tick), .div_wrap_i(div_wrap),
    .cmp_i(cmp_raw), .shift_en_o(shift_en), .shift_dir_o(shift_dir),
    .div_sel_o(div_sel_o)
  );

  dpwm_therm_sr #(.NSTG(NSTG), .RST_ONES(RST_ONES)) sr_u (
    .clk(clk), .rst_n(rst_sync_n), .shift_en_i(shift_en),
    .shift_dir_i(shift_dir), .code_o(duty_code_o)
  );

  dpwm_delay_chain #(.NSTG(NSTG), .STAGE_CYC(STAGE_CYC)) dl_u (
    .clk(clk), .rst_n(rst_sync_n), .start_i(ref_tick),
    .code_i(duty_code_o), .pwm_o(pwm_o)
  );
endmodule

// File: rtl/dpwm_top_chk.sv
module dpwm_top_chk #(
  parameter int NSTG = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ref_tick,
  input logic            shift_en,
  input logic            div_wrap,
  input logic            div_sel,
  input logic            pwm,
  input logic [NSTG-1:0] code
);
  logic [NSTG:0] code_inc;
  assign code_inc = {1'b0, code} + 1'b1;

  // R4
  therm_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(code_inc) == 1));

  // R7
  floor_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    code[0]);

  // R4
  code_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(code) |-> $past(shift_en));

  // R9
  window_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && div_sel) |-> div_wrap);

  // R2
  pwm_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwm) |-> $past(ref_tick));

  // R11
  sel_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(div_sel) |-> $past(ref_tick));
endmodule

bind dpwm_top dpwm_top_chk #(.NSTG(NSTG)) chk_i (
  .clk(clk), .rst_n(rst_sync_n), .ref_tick(ref_tick), .shift_en(shift_en),
  .div_wrap(div_wrap), .div_sel(div_sel_o), .pwm(pwm_o), .code(duty_code_o)
);

// File: tb/dpwm_top_tb_top.sv
`timescale 1ns/1ps
module dpwm_top_tb_top;
  localparam int NSTG  = 32;
  localparam int STAGE = 2;
  localparam int REF   = 80;
  localparam int NVEC  = 6;
  // fields: [9] above_hi, [8] below_lo, [7] below_ref, [6:0] ticks
  localparam logic [9:0] VEC [NVEC] = '{
    {1'b0, 1'b1, 1'b1, 7'd20},
    {1'b0, 1'b0, 1'b0, 7'd34},
    {1'b1, 1'b0, 1'b0, 7'd40},
    {1'b0, 1'b0, 1'b1, 7'd20},
    {1'b1, 1'b0, 1'b1, 7'd10},
    {1'b0, 1'b1, 1'b0, 7'd5}
  };

  logic clk, rst_n, hi, lo, up, pwm, dsel;
  logic [NSTG-1:0] code;
  int checks, fails;
  int m_ones, m_cnt;
  logic m1_hi, m1_lo, m1_up, m2_hi, m2_lo, m2_up;

  dpwm_top #(.NSTG(NSTG), .STAGE_CYC(STAGE), .REF_CYC(REF), .DIV_RATIO(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .vout_above_hi_i(hi), .vout_below_lo_i(lo),
    .vout_below_ref_i(up), .pwm_o(pwm), .duty_code_o(code), .div_sel_o(dsel)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [NSTG-1:0] therm(input int k);
    logic [NSTG-1:0] v;
    v = '0;
    for (int i = 0; i < NSTG; i++) if (i < k) v[i] = 1'b1;
    return v;
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_ones = 16; m_cnt = 0;
    m1_hi = 0; m1_lo = 0; m1_up = 0; m2_hi = 0; m2_lo = 0; m2_up = 0;
  endtask

  // At the negedge after a tick edge: update model, apply inputs, check, measure pulse.
  task automatic ptick(input logic nhi, input logic nlo, input logic nup);
    int width, rises;
    logic prev;
    if (m2_hi || m2_lo || m_cnt == 15) begin
      if (m2_up) m_ones = (m_ones < NSTG) ? m_ones + 1 : NSTG;  // R4 R6 R8
      else       m_ones = (m_ones > 1) ? m_ones - 1 : 1;       // R5 R7 R9
    end
    m_cnt = (m_cnt + 1) % 16;
    m2_hi = m1_hi; m2_lo = m1_lo; m2_up = m1_up;  // R10
    m1_hi = hi; m1_lo = lo; m1_up = up;
    hi = nhi; lo = nlo; up = nup;
    check("R4/R5 code", code, therm(m_ones));
    check("R11 div_sel", dsel, !m2_hi && !m2_lo);
    check("R2 pwm start", pwm, 1);
    width = 0; rises = 0; prev = 1'b1;
    for (int i = 0; i < REF; i++) begin
      if (pwm) width++;
      if (pwm && !prev) rises++;
      prev = pwm;
      @(negedge clk);
    end
    check("R3 width", width, (m_ones + 1) * STAGE);
    check("R2 single pulse", rises, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    checks = 0; fails = 0;
    hi = 0; lo = 0; up = 0; rst_n = 0;
    model_reset();
    repeat (3) @(negedge clk);
    check("R1 reset code", code, therm(16));
    check("R1 reset pwm", pwm, 0);
    check("R1 reset div_sel", dsel, 1);
    rst_n = 1;
    repeat (REF + 2) @(posedge clk);
    @(negedge clk);
    for (int v = 0; v < NVEC; v++) begin
      for (int t = 0; t < int'(VEC[v][6:0]); t++) ptick(VEC[v][9], VEC[v][8], VEC[v][7]);
    end
    // Directed: mid-run reset, then divider restarts from zero (R1, R9)
    hi = 1; lo = 0; up = 0;
    repeat (5) ptick(1'b1, 1'b0, 1'b0);
    rst_n = 0;
    repeat (3) @(negedge clk);
    check("R1 mid reset code", code, therm(16));
    check("R1 mid reset pwm", pwm, 0);
    check("R1 mid reset div_sel", dsel, 1);
    model_reset();
    hi = 0; lo = 0; up = 1;
    rst_n = 1;
    repeat (REF + 2) @(posedge clk);
    @(negedge clk);
    repeat (20) ptick(1'b0, 1'b0, 1'b1);  // R9: first in-window step at 16th tick
    check("R9 one window step", code, therm(17));
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule